// File: doc/BRIEF.md
# Low-Power Listening and Wake Timer Controller

This block sequences the operating mode of a low-frequency wake-up receiver. It runs on a fast system clock, and a tick strobe marks the 32.768 kHz time base. All of its timing is counted in those ticks. While it listens, it either keeps the receive channel powered without a break or duty-cycles it. In duty-cycled mode the channel is powered for a fixed 1 ms window and then switched off for a selectable time. The wake output rises when a real detection occurs. A detection comes from the correlator when correlation is enabled. When correlation is disabled, a detection is a carrier that stays present long enough.

Once awake, the block holds the wake state until a clear strobe arrives or until an optional timeout runs out. While it listens, it can also emit periodic forced wake pulses. These pulses are only a few ticks wide, so a host can tell them apart from a real wake by their width. A real detection that arrives during such a pulse turns it into a latched wake. Power-down stops everything.

Top module: `lp_wake_ctrl`

## Requirements
- R1: While `pwd_i` is high, `chan_en_o` and `wake_o` are low from the next clock on, and neither correlator requests nor carrier can raise `wake_o`.
- R2: With `onoff_en_i` low and the block listening, `chan_en_o` stays high without interruption.
- R3: With `onoff_en_i` high, `chan_en_o` alternates between 33 ticks high and an off time set by `off_code_i`: 0=33, 1=66, 2=131, 3=262 ticks.
- R4: `art_code_i` selects the forced-wake period. 0 disables it. Codes 1..7 give 1 s, 5 s, 20 s, 2 min, 15 min, 1 h and 2 h, where 1 s is 32768 ticks. Successive forced pulses rise exactly one period apart.
- R5: A forced wake holds `wake_o` high for exactly 4 ticks, whatever the inputs are doing, and then listening resumes.
- R6: With `corr_en_i`=1, a one-cycle `corr_wake_i` during listening raises `wake_o` on the next clock. Carrier alone never wakes.
- R7: With `corr_en_i`=0, a wake needs `carrier_i` high on 18 consecutive ticks while the channel is enabled. `wake_o` rises on the clock after the 18th tick. A burst of 17 ticks and any `corr_wake_i` have no effect.
- R8: A latched wake stays high until `clear_wake_i`, or indefinitely when `tout_code_i`=0. A clear drops `wake_o` on the next clock.
- R9: With `tout_code_i`=n (1..7), a latched wake lasts round(n*50 ms) ticks. Codes 1, 2 and 3 give 1638, 3277 and 4915 ticks.
- R10: A detection during a forced pulse turns the pulse into a latched wake that outlasts the 4 ticks.
- R11: Timers and carrier qualification advance only on cycles with `tick_i` high.
- R12: During a latched wake, `chan_en_o` stays high even in duty-cycled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe of the 32.768 kHz time base |
| pwd_i | input | 1 | Power-down |
| onoff_en_i | input | 1 | Duty-cycled listening enable |
| off_code_i | input | 2 | Channel off-time select |
| art_code_i | input | 3 | Forced-wake period select |
| tout_code_i | input | 3 | Post-wake timeout select |
| corr_en_i | input | 1 | Correlator enable |
| carrier_i | input | 1 | Carrier detected by the channel |
| corr_wake_i | input | 1 | Pattern-match wake request from the correlator |
| clear_wake_i | input | 1 | Clear-wake strobe |
| chan_en_o | output | 1 | Receive channel enable |
| wake_o | output | 1 | Wake output |

## Verification
The duty cycle is measured as run lengths of `chan_en_o` for every off-time code. This separates the four off durations from each other and from the fixed on window. Latched wakes are timed for several timeout codes and for the no-timeout case. The resulting widths distinguish the 50 ms steps from the 4-tick forced pulse and from an unbounded hold. Carrier bursts of 17 and 18 ticks, with tick gating and both correlator settings, show which input actually qualifies a wake. A correlator hit placed inside a forced pulse shows that a real detection takes priority over the pulse.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [1:0] {
        ST_DOWN   = 2'd0,
        ST_LISTEN = 2'd1,
        ST_PULSE  = 2'd2,
        ST_AWAKE  = 2'd3
    } lpw_state_e;

    // round(num * hz / den)
    function automatic int unsigned scale_ticks(input int unsigned num,
                                                input int unsigned den,
                                                input int unsigned hz);
        longint unsigned prod;
        prod = 64'(num) * 64'(hz) + 64'(den / 2);
        return 32'(prod / 64'(den));
    endfunction

    function automatic int unsigned off_ticks(input logic [1:0] code,
                                              input int unsigned hz);
        return scale_ticks(32'd1 << code, 32'd1000, hz);
    endfunction

    function automatic int unsigned art_seconds(input logic [2:0] code);
        case (code)
            3'd1:    return 32'd1;
            3'd2:    return 32'd5;
            3'd3:    return 32'd20;
            3'd4:    return 32'd120;
            3'd5:    return 32'd900;
            3'd6:    return 32'd3600;
            3'd7:    return 32'd7200;
            default: return 32'd0;
        endcase
    endfunction

    function automatic int unsigned art_ticks(input logic [2:0] code,
                                              input int unsigned hz);
        return art_seconds(code) * hz;
    endfunction

    function automatic int unsigned tout_ticks(input logic [2:0] code,
                                               input int unsigned hz);
        return scale_ticks(32'd50 * {29'd0, code}, 32'd1000, hz);
    endfunction

endpackage

// File: rtl/lpw_duty_gate.sv
module lpw_duty_gate
    import lpw_pkg::*;
#(
    parameter int unsigned TICK_HZ = 32768
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       active_i,
    input  logic [1:0] off_code_i,
    output logic       on_o
);
    localparam int unsigned ON_TICKS = scale_ticks(32'd1, 32'd1000, TICK_HZ);
    localparam int unsigned OFF_MAX  = off_ticks(2'd3, TICK_HZ);
    localparam int unsigned SPAN     = (OFF_MAX > ON_TICKS) ? OFF_MAX : ON_TICKS;
    localparam int DW = $clog2(SPAN + 1);

    logic          phase_off;
    logic [DW-1:0] cnt;
    logic [DW-1:0] off_lim [4];
    logic [DW-1:0] on_lim;

    assign on_lim = DW'(ON_TICKS - 1);

    for (genvar g = 0; g < 4; g++) begin : g_off_lim
        assign off_lim[g] = DW'(off_ticks(2'(g), TICK_HZ) - 1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !active_i) begin
            phase_off <= 1'b0;
            cnt       <= '0;
        end else if (tick_i) begin
            if (!phase_off) begin
                if (cnt >= on_lim) begin
                    phase_off <= 1'b1;
                    cnt       <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt >= off_lim[off_code_i]) begin
                    phase_off <= 1'b0;
                    cnt       <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign on_o = !phase_off;

    assert_on_window_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!phase_off) |-> (cnt <= on_lim));

endmodule

// File: rtl/lpw_art_timer.sv
module lpw_art_timer
    import lpw_pkg::*;
#(
    parameter int unsigned TICK_HZ = 32768
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic [2:0] code_i,
    output logic       fire_o
);
    localparam int AW = $clog2(art_ticks(3'd7, TICK_HZ) + 1);

    logic [AW-1:0] cnt;
    logic [AW-1:0] lim [8];
    logic          en;

    for (genvar g = 0; g < 8; g++) begin : g_lim
        assign lim[g] = AW'(art_ticks(3'(g), TICK_HZ) - 1);
    end

    assign en     = run_i && (code_i != 3'd0);
    assign fire_o = en && tick_i && (cnt >= lim[code_i]);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= (cnt >= lim[code_i]) ? '0 : cnt + 1'b1;
        end
    end

    assert_fire_gap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (fire_o && lim[code_i] != '0) |=> !fire_o);

endmodule

// File: rtl/lpw_carrier_qual.sv
module lpw_carrier_qual
    import lpw_pkg::*;
#(
    parameter int unsigned TICK_HZ = 32768
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic en_i,
    input  logic carrier_i,
    output logic hit_o
);
    localparam int unsigned CAR_TICKS = scale_ticks(32'd550, 32'd1000000, TICK_HZ);
    localparam int CW = $clog2(CAR_TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || (tick_i && !carrier_i)) begin
            cnt <= '0;
        end else if (tick_i && cnt != CW'(CAR_TICKS)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit_o = (cnt == CW'(CAR_TICKS));

    assert_hit_needs_carrier_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hit_o) |-> $past(carrier_i));

endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int unsigned TICK_HZ = 32768
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       pwd_i,
    input  logic       onoff_en_i,
    input  logic [1:0] off_code_i,
    input  logic [2:0] art_code_i,
    input  logic [2:0] tout_code_i,
    input  logic       corr_en_i,
    input  logic       carrier_i,
    input  logic       corr_wake_i,
    input  logic       clear_wake_i,
    output logic       chan_en_o,
    output logic       wake_o
);
    localparam int unsigned PULSE_TICKS = scale_ticks(32'd128, 32'd1000000, TICK_HZ);
    localparam int unsigned HOLD_MAX    = tout_ticks(3'd7, TICK_HZ);
    localparam int HOLD_W = $clog2(HOLD_MAX + 1);

    lpw_state_e        state_q, state_d;
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] tout_lim [8];
    logic              listening, duty_on, car_hit, art_fire, det;
    logic              pulse_done, tout_done;

    for (genvar g = 0; g < 8; g++) begin : g_tout_lim
        assign tout_lim[g] = HOLD_W'(tout_ticks(3'(g), TICK_HZ) - 1);
    end

    assign listening = (state_q == ST_LISTEN) || (state_q == ST_PULSE);

    lpw_duty_gate #(.TICK_HZ(TICK_HZ)) u_duty (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick_i),
        .active_i   (listening && onoff_en_i),
        .off_code_i (off_code_i),
        .on_o       (duty_on)
    );

    assign chan_en_o = (state_q == ST_AWAKE) || (listening && duty_on);
    assign wake_o    = (state_q == ST_PULSE) || (state_q == ST_AWAKE);

    lpw_carrier_qual #(.TICK_HZ(TICK_HZ)) u_carq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .en_i      (listening && !corr_en_i && chan_en_o),
        .carrier_i (carrier_i),
        .hit_o     (car_hit)
    );

    lpw_art_timer #(.TICK_HZ(TICK_HZ)) u_art (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick_i),
        .run_i  (state_q != ST_DOWN),
        .code_i (art_code_i),
        .fire_o (art_fire)
    );

    assign det        = corr_en_i ? corr_wake_i : car_hit;
    assign pulse_done = tick_i && (hold_q >= HOLD_W'(PULSE_TICKS - 1));
    assign tout_done  = (tout_code_i != 3'd0) && tick_i && (hold_q >= tout_lim[tout_code_i]);

    always_comb begin
        state_d = state_q;
        if (pwd_i) begin
            state_d = ST_DOWN;
        end else begin
            case (state_q)
                ST_DOWN:   state_d = ST_LISTEN;
                ST_LISTEN: begin
                    if (det)           state_d = ST_AWAKE;
                    else if (art_fire) state_d = ST_PULSE;
                end
                ST_PULSE: begin
                    if (det)                             state_d = ST_AWAKE;
                    else if (clear_wake_i || pulse_done) state_d = ST_LISTEN;
                end
                ST_AWAKE: begin
                    if (clear_wake_i || tout_done) state_d = ST_LISTEN;
                end
                default:   state_d = ST_DOWN;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_DOWN;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                hold_q <= '0;
            else if (tick_i && hold_q != '1)
                hold_q <= hold_q + 1'b1;
        end
    end

    assert_pd_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        pwd_i |=> (!wake_o && !chan_en_o));

    assert_corr_wake_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LISTEN && !pwd_i && corr_en_i && corr_wake_i) |=> wake_o);

    assert_pulse_bound_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_PULSE) |-> (hold_q < HOLD_W'(PULSE_TICKS)));

    assert_clear_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_AWAKE && clear_wake_i && !pwd_i) |=> (state_q == ST_LISTEN));

endmodule

// File: tb/lp_wake_ctrl_tb.sv
`timescale 1ns/1ps
module lp_wake_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst, tick, pwd, onoff, corr_en, carrier, corr_wake, clear_wake;
    logic [1:0] off_code;
    logic [2:0] art_code, tout_code;
    logic       chan, wake;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #5 clk = ~clk;

    lp_wake_ctrl u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .tick_i       (tick),
        .pwd_i        (pwd),
        .onoff_en_i   (onoff),
        .off_code_i   (off_code),
        .art_code_i   (art_code),
        .tout_code_i  (tout_code),
        .corr_en_i    (corr_en),
        .carrier_i    (carrier),
        .corr_wake_i  (corr_wake),
        .clear_wake_i (clear_wake),
        .chan_en_o    (chan),
        .wake_o       (wake)
    );

    // {kind (0 = duty off time, 1 = wake timeout), code, expected ticks}
    localparam logic [19:0] VEC [7] = '{
        {1'b0, 3'd0, 16'd33},
        {1'b0, 3'd1, 16'd66},
        {1'b0, 3'd2, 16'd131},
        {1'b0, 3'd3, 16'd262},
        {1'b1, 3'd1, 16'd1638},
        {1'b1, 3'd2, 16'd3277},
        {1'b1, 3'd3, 16'd4915}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic probe(input bit sel);
        return sel ? chan : wake;
    endfunction

    task automatic wait_for(input bit sel, input logic v, input int maxc);
        for (int k = 0; k < maxc && probe(sel) != v; k++) @(negedge clk);
    endtask

    task automatic run_len(input bit sel, input logic v, input int maxc, output int n);
        n = 0;
        while (probe(sel) == v && n < maxc) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_corr();
        corr_wake = 1'b1; @(negedge clk); corr_wake = 1'b0;
    endtask

    task automatic pulse_clear();
        clear_wake = 1'b1; @(negedge clk); clear_wake = 1'b0;
    endtask

    initial begin
        int n, n1, n0;
        rst = 1'b1; tick = 1'b1; pwd = 1'b0; onoff = 1'b0; corr_en = 1'b1;
        carrier = 1'b0; corr_wake = 1'b0; clear_wake = 1'b0;
        off_code = 2'd0; art_code = 3'd0; tout_code = 3'd0;
        repeat (3) @(negedge clk);
        chk("reset wake", int'(wake), 0);
        chk("reset chan", int'(chan), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 chan after reset", int'(chan), 1);
        run_len(1'b1, 1'b1, 300, n);
        chk("R2 continuous channel", n, 300);

        // R3 / R9 vector table
        foreach (VEC[i]) begin
            if (VEC[i][19] == 1'b0) begin
                corr_en = 1'b1; onoff = 1'b1; off_code = VEC[i][17:16];
                wait_for(1'b1, 1'b0, 2000);
                wait_for(1'b1, 1'b1, 2000);
                run_len(1'b1, 1'b1, 2000, n1);
                run_len(1'b1, 1'b0, 2000, n0);
                chk("R3 on window", n1, 33);
                chk("R3 off time", n0, int'(VEC[i][15:0]));
            end else begin
                onoff = 1'b0; corr_en = 1'b1; tout_code = VEC[i][18:16];
                repeat (2) @(negedge clk);
                pulse_corr();
                run_len(1'b0, 1'b1, 20000, n);
                chk("R9 timeout width", n, int'(VEC[i][15:0]));
            end
        end
        tout_code = 3'd0; onoff = 1'b0;
        repeat (3) @(negedge clk);

        // R6: correlator path
        corr_en = 1'b1; carrier = 1'b1;
        repeat (60) @(negedge clk);
        chk("R6 carrier alone ignored", int'(wake), 0);
        carrier = 1'b0;
        pulse_corr();
        chk("R6 correlator wake", int'(wake), 1);
        pulse_clear();
        chk("R8 clear drops wake", int'(wake), 0);

        // R7: carrier qualification
        corr_en = 1'b0;
        @(negedge clk);
        pulse_corr();
        repeat (3) @(negedge clk);
        chk("R7 corr request ignored", int'(wake), 0);
        carrier = 1'b1;
        repeat (17) @(negedge clk);
        carrier = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 17-tick burst", int'(wake), 0);
        carrier = 1'b1;
        repeat (18) @(negedge clk);
        chk("R7 before qualification", int'(wake), 0);
        @(negedge clk);
        chk("R7 qualified wake", int'(wake), 1);
        carrier = 1'b0;
        pulse_clear();
        chk("R8 clear after carrier wake", int'(wake), 0);

        // R11: no tick, no progress
        tick = 1'b0; carrier = 1'b1;
        repeat (60) @(negedge clk);
        chk("R11 no tick no wake", int'(wake), 0);
        tick = 1'b1;
        repeat (25) @(negedge clk);
        chk("R11 resumes on tick", int'(wake), 1);
        carrier = 1'b0;
        pulse_clear();

        // R8: hold with timeout disabled
        corr_en = 1'b1; tout_code = 3'd0;
        pulse_corr();
        run_len(1'b0, 1'b1, 3000, n);
        chk("R8 held without timeout", n, 3000);
        pulse_clear();
        chk("R8 clear ends hold", int'(wake), 0);

        // R12: channel stays on while awake in duty mode
        onoff = 1'b1; off_code = 2'd3;
        wait_for(1'b1, 1'b0, 2000);
        pulse_corr();
        run_len(1'b1, 1'b1, 400, n);
        chk("R12 channel on during wake", n, 400);
        pulse_clear();
        onoff = 1'b0;

        // R1: power-down
        pwd = 1'b1;
        @(negedge clk);
        chk("R1 chan off", int'(chan), 0);
        chk("R1 wake off", int'(wake), 0);
        pulse_corr();
        carrier = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1 no wake in power-down", int'(wake), 0);
        carrier = 1'b0; pwd = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 channel back after power-down", int'(chan), 1);

        // R4 / R5 / R10: forced wakes
        corr_en = 1'b1; art_code = 3'd1;
        wait_for(1'b0, 1'b1, 40000);
        run_len(1'b0, 1'b1, 100, n1);
        chk("R5 forced pulse width", n1, 4);
        run_len(1'b0, 1'b0, 40000, n0);
        chk("R4 forced period", n1 + n0, 32768);
        pulse_corr();
        art_code = 3'd0;
        repeat (10) @(negedge clk);
        chk("R10 detection latches", int'(wake), 1);
        chk("R12 chan during latched wake", int'(chan), 1);
        pulse_clear();
        chk("R8 clear after latched pulse", int'(wake), 0);
        run_len(1'b0, 1'b0, 33000, n);
        chk("R4 code 0 disables", n, 33000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule